// File: doc/BRIEF.md
# Latched-Address SRAM Access Sequencer

This block sits between a simple host request port and an external static RAM that latches its address, chip enable and write data internally. A host hands over one request at a time through a ready/valid handshake; each request is a read or a write and carries an address, a data word of two byte lanes, and a per-lane write mask. The sequencer drives the RAM's address-latch enable, data-latch enable, active-low chip enable, two active-low lane write strobes and the active-low output enable. For a read, it returns the captured word with a one-cycle valid pulse.

Every analogue timing limit of the RAM (address setup and hold around the latch closing, latch-open pulse width, data setup and hold around the data latch closing, write pulse width, cycle time and read access time) is a parameter in picoseconds. Each is converted to whole clock cycles by rounding up, with a floor of one cycle. A write runs through four phases: the address is presented with the latch open, the address latch closes while the data latch opens, the data latch closes and the selected lane strobes pulse low, and a recovery phase closes the transaction. A read replaces the data and strobe phases with an output-enable wait of the access time.

Top module: `lsram_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it rises, `req_ready`=1, `mem_ce_n`=1, `mem_we_lo_n`=1, `mem_we_hi_n`=1, `mem_oe_n`=1, `mem_dlatch`=0, `mem_wdrive`=0 and `rd_valid`=0.
- R2: `req_ready` is high only when no transaction is in progress. A request is accepted on the rising edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low has no effect on the RAM contents.
- R3: From the accept edge, `mem_addr` carries the request address and `mem_ce_n` is low. `mem_alatch` stays high for exactly ceil(address setup / clock period) cycles before it falls. `mem_addr` does not change while `mem_ce_n` is low.
- R4: Once `mem_alatch` falls, it stays low as long as either lane write strobe is low. It rises no earlier than the edge on which both strobes are high again.
- R5: In a write, `mem_dlatch` is high for max(ceil(address hold), ceil(data setup)) cycles directly after the address latch closes. It falls before any lane strobe goes low. `mem_wdrive` is high with `mem_wdata` equal to the request data throughout the data-latch and strobe phases.
- R6: Write mask bit 0 selects the lower lane (data bits 8:0, strobe `mem_we_lo_n`). Bit 1 selects the upper lane (bits 17:9, strobe `mem_we_hi_n`). A selected lane's strobe is low for exactly max(ceil(write pulse), ceil(data hold)) cycles. A mask of 0 produces no strobe and leaves the word unchanged. `mem_oe_n` is never low during a strobe.
- R7: Both write strobes are high on the cycle where `mem_addr` changes and on the cycle before it.
- R8: In a read, `mem_oe_n` is low for ceil(access time) cycles after the address latch closes. The RAM data is captured on the edge that ends that wait. `rd_valid` is high for exactly one cycle, ceil(address setup)+ceil(access) cycles after the accept edge, with `rd_data` holding the word.
- R9: Every transaction ends with a recovery phase of max(ceil(latch-open width), ceil(cycle time)) cycles. During recovery `mem_ce_n`=1 and `mem_alatch`=1. `req_ready` returns after it.
- R10: Each cycle count equals the timing parameter divided by the clock period, rounded up, and is never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Word address |
| req_wdata | input | 2*LANE_W (18) | Write data |
| req_bmask | input | 2 | Lane write mask, bit 0 lower lane, bit 1 upper lane |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | 2*LANE_W (18) | Captured read data |
| mem_addr | output | ADDR_W (16) | Address to the RAM |
| mem_wdata | output | 2*LANE_W (18) | Write data to the RAM |
| mem_wdrive | output | 1 | Enables the write-data bus drivers |
| mem_rdata | input | 2*LANE_W (18) | Read data from the RAM |
| mem_alatch | output | 1 | Address/enable latch open (high = transparent) |
| mem_dlatch | output | 1 | Data-in latch open (high = transparent) |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_lo_n | output | 1 | Lower-lane write strobe, active low |
| mem_we_hi_n | output | 1 | Upper-lane write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
A wrong dwell count in any phase shows as a strobe run of the wrong length on the same transaction, and as `req_ready` or `rd_valid` arriving on the wrong cycle. A wrong state order shows as the address latch open during a strobe, or as the data latch still open when a strobe falls, on the first write that goes through the bad path. A mis-decoded mask or lane shows at the next read of that address as a merged word with the wrong lane. The bench runs every mask over a set of addresses and reads each result back.

// File: rtl/lsram_pkg.sv
package lsram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE        = 3'd0,
    ST_LATCH_ADDR  = 3'd1,
    ST_LATCH_DATA  = 3'd2,
    ST_WRITE_PULSE = 3'd3,
    ST_READ_WAIT   = 3'd4,
    ST_RECOVER     = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic alatch;
    logic dlatch;
    logic ce_n;
    logic we_lo_n;
    logic we_hi_n;
    logic oe_n;
    logic wdrive;
  } strobe_t;

  // Whole cycles covering a duration, at least one.
  function automatic int unsigned cycles_for(input int unsigned dur_ps,
                                             input int unsigned clk_ps);
    int unsigned c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Pin levels held during each phase.
  function automatic strobe_t decode_strobes(input seq_state_t st,
                                             input logic [1:0] lane_en);
    strobe_t s;
    s = '{alatch: 1'b1, dlatch: 1'b0, ce_n: 1'b1, we_lo_n: 1'b1,
          we_hi_n: 1'b1, oe_n: 1'b1, wdrive: 1'b0};
    case (st)
      ST_LATCH_ADDR: begin
        s.ce_n = 1'b0;
      end
      ST_LATCH_DATA: begin
        s.ce_n   = 1'b0;
        s.alatch = 1'b0;
        s.dlatch = 1'b1;
        s.wdrive = 1'b1;
      end
      ST_WRITE_PULSE: begin
        s.ce_n    = 1'b0;
        s.alatch  = 1'b0;
        s.wdrive  = 1'b1;
        s.we_lo_n = ~lane_en[0];
        s.we_hi_n = ~lane_en[1];
      end
      ST_READ_WAIT: begin
        s.ce_n   = 1'b0;
        s.alatch = 1'b0;
        s.oe_n   = 1'b0;
      end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lsram_dwell_timer.sv
module lsram_dwell_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lsram_seq_fsm.sv
module lsram_seq_fsm
  import lsram_pkg::*;
#(
  parameter int unsigned CNT_W = 2,
  parameter int unsigned D_ASU = 1,
  parameter int unsigned D_LD  = 1,
  parameter int unsigned D_WP  = 2,
  parameter int unsigned D_ACC = 2,
  parameter int unsigned D_REC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output seq_state_t       state_q,
  output seq_state_t       state_d,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             rd_capture
);

  localparam logic [CNT_W-1:0] L_ASU = CNT_W'(D_ASU - 1);
  localparam logic [CNT_W-1:0] L_LD  = CNT_W'(D_LD - 1);
  localparam logic [CNT_W-1:0] L_WP  = CNT_W'(D_WP - 1);
  localparam logic [CNT_W-1:0] L_ACC = CNT_W'(D_ACC - 1);
  localparam logic [CNT_W-1:0] L_REC = CNT_W'(D_REC - 1);

  logic is_write_q;

  assign accept     = req_valid && (state_q == ST_IDLE);
  assign rd_capture = (state_q == ST_READ_WAIT) && expired;

  always_comb begin
    state_d    = state_q;
    timer_load = 1'b0;
    timer_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d    = ST_LATCH_ADDR;
          timer_load = 1'b1;
          timer_val  = L_ASU;
        end
      end
      ST_LATCH_ADDR: begin
        if (expired) begin
          timer_load = 1'b1;
          if (is_write_q) begin
            state_d   = ST_LATCH_DATA;
            timer_val = L_LD;
          end else begin
            state_d   = ST_READ_WAIT;
            timer_val = L_ACC;
          end
        end
      end
      ST_LATCH_DATA: begin
        if (expired) begin
          state_d    = ST_WRITE_PULSE;
          timer_load = 1'b1;
          timer_val  = L_WP;
        end
      end
      ST_WRITE_PULSE, ST_READ_WAIT: begin
        if (expired) begin
          state_d    = ST_RECOVER;
          timer_load = 1'b1;
          timer_val  = L_REC;
        end
      end
      ST_RECOVER: begin
        if (expired) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_write_q <= 1'b0;
    end else if (accept) begin
      is_write_q <= req_write;
    end
  end

endmodule

// File: rtl/lsram_strobe_gen.sv
module lsram_strobe_gen
  import lsram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t state_d,
  input  logic [1:0] lane_en,
  output strobe_t    pins_q
);

  strobe_t pins_d;

  assign pins_d = decode_strobes(state_d, lane_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= decode_strobes(ST_IDLE, 2'b00);
    end else begin
      pins_q <= pins_d;
    end
  end

endmodule

// File: rtl/lsram_rd_capture.sv
module lsram_rd_capture #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/lsram_seq.sv
module lsram_seq
  import lsram_pkg::*;
#(
  parameter int unsigned ADDR_W           = 16,
  parameter int unsigned LANE_W           = 9,
  parameter int unsigned CLK_PS           = 5000,
  parameter int unsigned T_ADDR_SETUP_PS  = 2000,
  parameter int unsigned T_ADDR_HOLD_PS   = 3000,
  parameter int unsigned T_ALATCH_OPEN_PS = 5000,
  parameter int unsigned T_DATA_SETUP_PS  = 2000,
  parameter int unsigned T_DATA_HOLD_PS   = 2000,
  parameter int unsigned T_WR_PULSE_PS    = 9000,
  parameter int unsigned T_CYCLE_PS       = 10000,
  parameter int unsigned T_ACCESS_PS      = 10000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [2*LANE_W-1:0]   req_wdata,
  input  logic [1:0]            req_bmask,
  output logic                  rd_valid,
  output logic [2*LANE_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [2*LANE_W-1:0]   mem_wdata,
  output logic                  mem_wdrive,
  input  logic [2*LANE_W-1:0]   mem_rdata,
  output logic                  mem_alatch,
  output logic                  mem_dlatch,
  output logic                  mem_ce_n,
  output logic                  mem_we_lo_n,
  output logic                  mem_we_hi_n,
  output logic                  mem_oe_n
);

  localparam int unsigned DATA_W = 2 * LANE_W;

  // R10: cycle counts from picosecond limits
  localparam int unsigned N_ASU = cycles_for(T_ADDR_SETUP_PS, CLK_PS);
  localparam int unsigned N_AH  = cycles_for(T_ADDR_HOLD_PS, CLK_PS);
  localparam int unsigned N_ALO = cycles_for(T_ALATCH_OPEN_PS, CLK_PS);
  localparam int unsigned N_DSU = cycles_for(T_DATA_SETUP_PS, CLK_PS);
  localparam int unsigned N_DH  = cycles_for(T_DATA_HOLD_PS, CLK_PS);
  localparam int unsigned N_WP  = cycles_for(T_WR_PULSE_PS, CLK_PS);
  localparam int unsigned N_CYC = cycles_for(T_CYCLE_PS, CLK_PS);
  localparam int unsigned N_ACC = cycles_for(T_ACCESS_PS, CLK_PS);

  localparam int unsigned D_ASU = N_ASU;
  localparam int unsigned D_LD  = max2(N_AH, N_DSU);
  localparam int unsigned D_WP  = max2(N_WP, N_DH);
  localparam int unsigned D_ACC = N_ACC;
  localparam int unsigned D_REC = max2(N_ALO, N_CYC);
  localparam int unsigned D_MAX = max2(max2(max2(D_ASU, D_LD), max2(D_WP, D_ACC)), D_REC);
  localparam int unsigned CNT_W = (D_MAX < 2) ? 1 : $clog2(D_MAX);

  seq_state_t        state_q;
  seq_state_t        state_d;
  logic              accept;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              timer_expired;
  logic              rd_capture;
  strobe_t           pins_q;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        mask_q;

  lsram_seq_fsm #(
    .CNT_W (CNT_W),
    .D_ASU (D_ASU),
    .D_LD  (D_LD),
    .D_WP  (D_WP),
    .D_ACC (D_ACC),
    .D_REC (D_REC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .expired    (timer_expired),
    .state_q    (state_q),
    .state_d    (state_d),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .rd_capture (rd_capture)
  );

  lsram_dwell_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  lsram_strobe_gen u_strobes (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .lane_en (mask_q),
    .pins_q  (pins_q)
  );

  lsram_rd_capture #(
    .DATA_W (DATA_W)
  ) u_rdcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (rd_capture),
    .mem_rdata (mem_rdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  // Request hold registers, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_bmask;
    end
  end

  assign req_ready   = (state_q == ST_IDLE);
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_wdrive  = pins_q.wdrive;
  assign mem_alatch  = pins_q.alatch;
  assign mem_dlatch  = pins_q.dlatch;
  assign mem_ce_n    = pins_q.ce_n;
  assign mem_we_lo_n = pins_q.we_lo_n;
  assign mem_we_hi_n = pins_q.we_hi_n;
  assign mem_oe_n    = pins_q.oe_n;

endmodule

// File: rtl/lsram_seq_checker.sv
module lsram_seq_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_wdrive,
  input logic              mem_alatch,
  input logic              mem_dlatch,
  input logic              mem_ce_n,
  input logic              mem_we_lo_n,
  input logic              mem_we_hi_n,
  input logic              mem_oe_n
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_lo_n && mem_we_hi_n && mem_oe_n));

  assert_latch_closed_in_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_lo_n || !mem_we_hi_n) |-> (!mem_alatch && !mem_ce_n));

  assert_alatch_reopens_after_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_alatch) |-> (mem_we_lo_n && mem_we_hi_n));

  assert_data_latch_shut_in_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_lo_n || !mem_we_hi_n) |-> (!mem_dlatch && mem_wdrive));

  assert_data_driven_while_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dlatch |-> (mem_wdrive && !mem_alatch && !mem_ce_n));

  assert_no_oe_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_lo_n && mem_we_hi_n && !mem_wdrive));

  assert_addr_moves_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |->
      (mem_we_lo_n && mem_we_hi_n && $past(mem_we_lo_n) && $past(mem_we_hi_n)));

  assert_rd_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind lsram_seq lsram_seq_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (2*LANE_W)
) u_lsram_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .rd_valid    (rd_valid),
  .mem_addr    (mem_addr),
  .mem_wdrive  (mem_wdrive),
  .mem_alatch  (mem_alatch),
  .mem_dlatch  (mem_dlatch),
  .mem_ce_n    (mem_ce_n),
  .mem_we_lo_n (mem_we_lo_n),
  .mem_we_hi_n (mem_we_hi_n),
  .mem_oe_n    (mem_oe_n)
);

// File: tb/test_lsram_seq.sv
`timescale 1ns/1ps
module test_lsram_seq;

  localparam int CLK_PS = 5000;

  function automatic int cyc(input int t_ps);
    int c;
    c = (t_ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R10: expected dwell counts, from the timing limits in picoseconds
  localparam int E_ASU = cyc(2000);
  localparam int E_LD  = mx(cyc(3000), cyc(2000));
  localparam int E_WP  = mx(cyc(9000), cyc(2000));
  localparam int E_ACC = cyc(10000);
  localparam int E_REC = mx(cyc(5000), cyc(10000));

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [15:0] req_addr;
  logic [17:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        rd_valid;
  logic [17:0] rd_data;
  logic [15:0] mem_addr;
  logic [17:0] mem_wdata;
  logic        mem_wdrive;
  logic [17:0] mem_rdata;
  logic        mem_alatch;
  logic        mem_dlatch;
  logic        mem_ce_n;
  logic        mem_we_lo_n;
  logic        mem_we_hi_n;
  logic        mem_oe_n;

  lsram_seq i_lsram_seq (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_bmask (req_bmask),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_wdrive (mem_wdrive),
    .mem_rdata (mem_rdata), .mem_alatch (mem_alatch), .mem_dlatch (mem_dlatch),
    .mem_ce_n (mem_ce_n), .mem_we_lo_n (mem_we_lo_n), .mem_we_hi_n (mem_we_hi_n),
    .mem_oe_n (mem_oe_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural latched RAM, 1024 words on address bits 9:0.
  logic [17:0] ram [1024];
  logic [17:0] shadow [1024];
  logic [9:0]  lat_a;
  logic [17:0] lat_d;

  always_latch if (mem_alatch) lat_a <= mem_addr[9:0];
  always_latch if (mem_dlatch) lat_d <= mem_wdata;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_lo_n) ram[lat_a][8:0]  <= lat_d[8:0];
    if (!mem_ce_n && !mem_we_hi_n) ram[lat_a][17:9] <= lat_d[17:9];
  end

  assign mem_rdata = (!mem_ce_n && !mem_oe_n) ? ram[lat_a] : 18'h0;

  // Pin monitor, sampled on the falling edge.
  logic [15:0] cur_addr = '0;
  logic [17:0] cur_data = '0;
  logic [1:0]  cur_mask = '0;
  int viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r7 = 0;
  int al_run = 0, dl_run = 0, we_run = 0, pulses = 0;
  bit seen_lo = 0, seen_hi = 0;
  logic [15:0] prev_addr = '0;
  logic        prev_we_ok = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && mem_addr != cur_addr) viol_r3++;
      if ((!mem_we_lo_n || !mem_we_hi_n) && mem_alatch) viol_r4++;
      if ((!mem_we_lo_n || !mem_we_hi_n) && mem_dlatch) viol_r5++;
      if ((mem_dlatch || !mem_we_lo_n || !mem_we_hi_n) &&
          (!mem_wdrive || mem_wdata != cur_data)) viol_r5++;
      if (mem_addr != prev_addr && !(prev_we_ok && mem_we_lo_n && mem_we_hi_n)) viol_r7++;
      prev_addr  = mem_addr;
      prev_we_ok = mem_we_lo_n && mem_we_hi_n;

      // R3: address latch open with the chip enabled, before it closes
      if (!mem_ce_n && mem_alatch) al_run++;
      else if (al_run > 0) begin
        check(al_run == E_ASU, "R3 alatch setup cycles", al_run, E_ASU);
        al_run = 0;
      end
      // R5: data latch open length
      if (mem_dlatch) dl_run++;
      else if (dl_run > 0) begin
        check(dl_run == E_LD, "R5 dlatch open cycles", dl_run, E_LD);
        dl_run = 0;
      end
      // R6: strobe length and lane selection
      if (!mem_we_lo_n || !mem_we_hi_n) begin
        we_run++;
        if (!mem_we_lo_n) seen_lo = 1;
        if (!mem_we_hi_n) seen_hi = 1;
      end else if (we_run > 0) begin
        check(we_run == E_WP, "R6 strobe cycles", we_run, E_WP);
        check({seen_hi, seen_lo} == cur_mask, "R6 strobe lanes", {seen_hi, seen_lo}, cur_mask);
        we_run = 0; seen_lo = 0; seen_hi = 0;
        pulses++;
      end
    end
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [17:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr  = a;
    cur_data  = d;
    cur_mask  = wr ? m : 2'b00;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_bmask = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [17:0] d,
                          input logic [1:0] m, input bit poke_busy);
    int cnt;
    int p0;
    p0 = pulses;
    issue(1'b1, a, d, m);
    cnt = 1;
    while (!req_ready) begin
      if (poke_busy && cnt == 2) begin
        // R2: request offered while busy must be ignored
        req_valid = 1'b1; req_write = 1'b1; req_bmask = 2'b11;
        req_addr = 16'h03FF; req_wdata = 18'h3FFFF;
      end
      if (poke_busy && cnt == 3) req_valid = 1'b0;
      @(negedge clk);
      cnt++;
    end
    req_valid = 1'b0;
    check(cnt == E_ASU + E_LD + E_WP + E_REC + 1, "R9 write turnaround", cnt,
          E_ASU + E_LD + E_WP + E_REC + 1);
    check((pulses - p0) == ((m != 2'b00) ? 1 : 0), "R6 strobe pulse count",
          pulses - p0, (m != 2'b00) ? 1 : 0);
    if (m[0]) shadow[a[9:0]][8:0]  = d[8:0];
    if (m[1]) shadow[a[9:0]][17:9] = d[17:9];
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    int cnt;
    int vcnt;
    int vat;
    logic [17:0] got;
    issue(1'b0, a, 18'h0, 2'b00);
    cnt = 1; vcnt = 0; vat = 0; got = '0;
    while (!req_ready) begin
      if (rd_valid) begin vcnt++; vat = cnt; got = rd_data; end
      @(negedge clk);
      cnt++;
    end
    if (rd_valid) vcnt++;
    check(vcnt == 1, "R8 read valid pulse count", vcnt, 1);
    check(vat == E_ASU + E_ACC + 1, "R8 read latency", vat, E_ASU + E_ACC + 1);
    check(got == shadow[a[9:0]], tag, got, shadow[a[9:0]]);
    check(cnt == E_ASU + E_ACC + E_REC + 1, "R9 read turnaround", cnt,
          E_ASU + E_ACC + E_REC + 1);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin ram[i] = '0; shadow[i] = '0; end
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_bmask = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check(req_ready && mem_ce_n && mem_we_lo_n && mem_we_hi_n && mem_oe_n &&
          !mem_dlatch && !mem_wdrive && !rd_valid, "R1 reset pins",
          {req_ready, mem_ce_n, mem_we_lo_n, mem_we_hi_n, mem_oe_n, mem_dlatch, mem_wdrive, rd_valid},
          8'b11111000);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && mem_ce_n && mem_we_lo_n && mem_we_hi_n && mem_oe_n &&
          !mem_dlatch && !mem_wdrive && !rd_valid, "R1 after reset",
          {req_ready, mem_ce_n, mem_we_lo_n, mem_we_hi_n, mem_oe_n, mem_dlatch, mem_wdrive, rd_valid},
          8'b11111000);

    // Sweep: every mask over eight addresses with distinct low bits.
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] a;
        logic [17:0] base;
        a    = 16'(i * 16'h1357 + 16'h00A5);
        base = 18'(i * 18'h0AB1 + m * 18'h1234) ^ 18'h25A5A;
        do_write(a, base, 2'b11, 1'b0);
        do_write(a, ~base, 2'(m), 1'b0);
        do_read(a, "R6 merged lanes after masked write");
      end
    end

    // R2: a request offered mid-transaction changes nothing.
    do_write(16'h8001, 18'h1C0DE, 2'b11, 1'b1);
    do_read(16'h03FF, "R2 busy request ignored");
    do_read(16'h8001, "R8 readback after busy poke");

    // Address-bit extremes.
    do_write(16'hFFFF, 18'h2AAAA, 2'b11, 1'b0);
    do_read(16'hFFFF, "R8 top address readback");
    do_write(16'h0000, 18'h15555, 2'b10, 1'b0);
    do_read(16'h0000, "R6 upper lane only at zero");

    check(viol_r3 == 0, "R3 address stable while enabled", viol_r3, 0);
    check(viol_r4 == 0, "R4 alatch closed during strobe", viol_r4, 0);
    check(viol_r5 == 0, "R5 data latch and drive order", viol_r5, 0);
    check(viol_r7 == 0, "R7 strobes high on address change", viol_r7, 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule